// File: doc/BRIEF.md
# Multiplexed Button Matrix Reader

This block presents eight active-low push buttons to a processor through one 8-bit register. The buttons form two groups of four: a direction pad and a set of action buttons. Software writes two group-select bits in the register. Only the chosen group, or the combination of both groups, appears on the four low data bits. Software then reads the register to get the button states.

Raw button levels enter through a two-flop synchronizer before they are used. The block watches the four visible key bits. When any of them falls from 1 to 0, it raises a one-cycle interrupt request. A fall can come from a new button press. It can also come from a select write that exposes a button that was already held.

Top module: `kp_matrix_reader`

## Requirements
- R1: While reset is high, and on the first cycle after it, `rd_data` is 8'hFF and `irq` is 0. After reset, both groups are deselected and all synchronized keys read released.
- R2: Bits 7 and 6 of `rd_data` always read 1.
- R3: A write with `wr_en` high loads `wr_data[5:4]` into the select field. From the next cycle, `rd_data[5:4]` returns that field. The written bits 7:6 and 3:0 have no effect on the read value.
- R4: With bit 4 = 0 and bit 5 = 1, `rd_data[3:0]` equals the synchronized direction inputs. The bit order is right on bit 0, left on bit 1, up on bit 2 and down on bit 3.
- R5: With bit 5 = 0 and bit 4 = 1, `rd_data[3:0]` equals the synchronized action inputs. The bit order is A on bit 0, B on bit 1, select on bit 2 and start on bit 3.
- R6: With both bit 4 and bit 5 = 0, each bit of `rd_data[3:0]` is the AND of the direction and action inputs of the same bit position.
- R7: With both bit 4 and bit 5 = 1, `rd_data[3:0]` reads 4'hF whatever the buttons are doing.
- R8: A change on a raw button input reaches `rd_data` after exactly two rising clock edges.
- R9: `irq` is high for the single cycle that follows the clock edge after any bit of `rd_data[3:0]` went from 1 to 0. This holds whether a press or a select write caused the fall.
- R10: A bit of `rd_data[3:0]` going from 0 to 1 does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; bits 5:4 are the group selects (0 = selected) |
| btn_dir_n | input | 4 | Raw direction buttons, active low: right, left, up, down on bits 0..3 |
| btn_act_n | input | 4 | Raw action buttons, active low: A, B, select, start on bits 0..3 |
| rd_data | output | 8 | Register read value |
| irq | output | 1 | One-cycle request on a falling visible key bit |

## Verification
The hardest interrupt to reach is the one caused by the select field rather than by the buttons. A button must already be held in a group that is not visible, and then a write must expose it. The bench therefore holds direction keys while only the action group is selected, and then writes a select value that adds the direction group. It does the same with both groups selected, so that the AND of a pressed key and a released key still pulls the line low. A behavioural model runs beside the design on every clock. It is checked against directed sequences and a long stretch of random presses and writes.

// File: rtl/kp_pkg.sv
package kp_pkg;

    localparam int KEYS_PER_GROUP = 4;
    localparam int REG_W          = 8;
    localparam int SEL_W          = 2;
    localparam int PAD_W          = REG_W - SEL_W - KEYS_PER_GROUP;

    typedef logic [KEYS_PER_GROUP-1:0] key_nib_t;

    // Select field, bit 5 then bit 4; a 0 selects the group
    typedef struct packed {
        logic act_off;
        logic dir_off;
    } grp_sel_t;

    typedef struct packed {
        logic down;
        logic up;
        logic left;
        logic right;
    } dir_keys_t;

    typedef struct packed {
        logic start;
        logic sel;
        logic b;
        logic a;
    } act_keys_t;

    localparam grp_sel_t SEL_NONE = '{act_off: 1'b1, dir_off: 1'b1};

    function automatic key_nib_t merge_groups(grp_sel_t s, dir_keys_t d, act_keys_t a);
        key_nib_t r;
        r = '1;
        if (!s.dir_off) r = r & key_nib_t'(d);
        if (!s.act_off) r = r & key_nib_t'(a);
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_reg(grp_sel_t s, key_nib_t k);
        return {{PAD_W{1'b1}}, s, k};
    endfunction

endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
    parameter int W       = 4,
    parameter int STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/kp_select_reg.sv
module kp_select_reg
    import kp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output grp_sel_t         sel
);
    localparam int SEL_LSB = KEYS_PER_GROUP;

    always_ff @(posedge clk) begin
        if (rst)        sel <= SEL_NONE;
        else if (wr_en) sel <= grp_sel_t'(wr_data[SEL_LSB +: SEL_W]);
    end
endmodule

// File: rtl/kp_fall_irq.sv
module kp_fall_irq
    import kp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  key_nib_t keys,
    output logic     irq
);
    key_nib_t prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '1;
            irq  <= 1'b0;
        end else begin
            prev <= keys;
            irq  <= |(prev & ~keys);
        end
    end
endmodule

// File: rtl/kp_matrix_reader.sv
module kp_matrix_reader
    import kp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [3:0] btn_dir_n,
    input  logic [3:0] btn_act_n,
    output logic [7:0] rd_data,
    output logic       irq
);
    localparam int RAW_W = 2 * KEYS_PER_GROUP;

    logic [RAW_W-1:0] raw_all;
    logic [RAW_W-1:0] syn_all;
    dir_keys_t        dir_s;
    act_keys_t        act_s;
    grp_sel_t         sel;
    key_nib_t         keys;

    assign raw_all = {btn_act_n, btn_dir_n};

    kp_sync #(.W(RAW_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_all),
        .q   (syn_all)
    );

    assign dir_s = dir_keys_t'(syn_all[KEYS_PER_GROUP-1:0]);
    assign act_s = act_keys_t'(syn_all[RAW_W-1:KEYS_PER_GROUP]);

    kp_select_reg i_sel (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .sel     (sel)
    );

    assign keys    = merge_groups(sel, dir_s, act_s);
    assign rd_data = pack_reg(sel, keys);

    kp_fall_irq i_irq (
        .clk  (clk),
        .rst  (rst),
        .keys (keys),
        .irq  (irq)
    );
endmodule

// File: rtl/kp_matrix_reader_chk.sv
module kp_matrix_reader_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       irq
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R1
    a_r1_reset_value: assert property (@(posedge clk)
        rst |=> (rd_data == 8'hFF && !irq));

    a_r2_pad_ones: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:6] == 2'b11);

    a_r3_select_load: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[5:4] == $past(wr_data[5:4]));

    a_r7_none_all_ones: assert property (@(posedge clk) disable iff (rst)
        (rd_data[5:4] == 2'b11) |-> (rd_data[3:0] == 4'hF));

    // R9 and R10
    a_r9_fall_raises: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && |($past(rd_data[3:0], 2) & ~$past(rd_data[3:0], 1))) |-> irq);

    a_r10_only_on_fall: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && irq) |-> |($past(rd_data[3:0], 2) & ~$past(rd_data[3:0], 1)));
endmodule

bind kp_matrix_reader kp_matrix_reader_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq     (irq)
);

// File: tb/test_kp_matrix_reader.sv
module test_kp_matrix_reader;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] btn_dir_n = 4'hF;
    logic [3:0] btn_act_n = 4'hF;
    logic [7:0] rd_data;
    logic       irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    kp_matrix_reader i_kp_matrix_reader (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .btn_dir_n(btn_dir_n), .btn_act_n(btn_act_n),
        .rd_data(rd_data), .irq(irq)
    );

    // Behavioural reference
    logic [3:0] q_dir[$];
    logic [3:0] q_act[$];
    logic [1:0] m_sel;
    logic [3:0] m_prev;
    logic       m_irq;

    function automatic logic [3:0] model_keys(logic [1:0] s, logic [3:0] d, logic [3:0] a);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            r[i] = 1'b1;
            if (s[0] == 1'b0 && d[i] == 1'b0) r[i] = 1'b0;
            if (s[1] == 1'b0 && a[i] == 1'b0) r[i] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [7:0] model_rd();
        return {2'b11, m_sel, model_keys(m_sel, q_dir[0], q_act[0])};
    endfunction

    always @(posedge clk) begin
        logic [3:0] cur;
        logic [3:0] tmp;
        if (rst) begin
            q_dir = '{4'hF, 4'hF};
            q_act = '{4'hF, 4'hF};
            m_sel = 2'b11;
            m_prev = 4'hF;
            m_irq = 1'b0;
        end else begin
            cur    = model_keys(m_sel, q_dir[0], q_act[0]);
            m_irq  = |(m_prev & ~cur);
            m_prev = cur;
            if (wr_en) m_sel = wr_data[5:4];
            q_dir.push_back(btn_dir_n); tmp = q_dir.pop_front();
            q_act.push_back(btn_act_n); tmp = q_act.pop_front();
        end
    end

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison at the falling edge
    always @(negedge clk) begin
        logic [7:0] e;
        string tag;
        if (!rst && q_dir.size() == 2) begin
            e = model_rd();
            check(rd_data[7:6] == 2'b11, "R2", rd_data, e);
            check(rd_data[5:4] == e[5:4], "R3", rd_data, e);
            case (e[5:4])
                2'b10:   tag = "R4";   // directions only
                2'b01:   tag = "R5";   // actions only
                2'b00:   tag = "R6";   // both, AND
                default: tag = "R7";   // none
            endcase
            check(rd_data[3:0] == e[3:0], tag, rd_data, e);
            check(irq == m_irq, m_irq ? "R9" : "R10", {7'd0, irq}, {7'd0, m_irq});
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        step(1);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        @(negedge clk);
        check(rd_data == 8'hFF && irq == 1'b0, "R1", rd_data, 8'hFF);
        rst = 1'b0;
        step(1);
        @(negedge clk);
        check(rd_data == 8'hFF && irq == 1'b0, "R1", rd_data, 8'hFF);
        step(1);

        // R3: junk in bits 7:6 and 3:0 ignored; directions selected (R4)
        wr(8'b0110_0101);
        step(2);
        // R8: change appears after exactly two edges
        btn_dir_n = 4'b1110;
        step(1);
        @(negedge clk);
        check(rd_data[3:0] == 4'hF, "R8", rd_data, 8'hEF);
        step(1);
        @(negedge clk);
        check(rd_data[3:0] == 4'hE, "R8", rd_data, 8'hEE);
        step(1);
        @(negedge clk);
        check(irq == 1'b1, "R9", {7'd0, irq}, 8'h01);
        step(1);
        @(negedge clk);
        check(irq == 1'b0, "R9", {7'd0, irq}, 8'h00);
        step(1);
        // R10: release, no request
        btn_dir_n = 4'hF;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(irq == 1'b0, "R10", {7'd0, irq}, 8'h00);
            step(1);
        end

        // R5: actions
        wr(8'h10);
        btn_act_n = 4'b0101; step(4);
        btn_act_n = 4'hF; step(4);

        // R9: held direction keys exposed by a select write
        btn_dir_n = 4'b1011; step(4);
        wr(8'h00);                 // both groups, R6
        step(4);
        btn_act_n = 4'b0111; step(4);
        btn_dir_n = 4'hF; step(4);
        wr(8'hF0);                 // neither, R7
        btn_dir_n = 4'h0; btn_act_n = 4'h0; step(4);
        wr(8'h20);                 // exposes all four, R9
        step(4);
        btn_dir_n = 4'hF; btn_act_n = 4'hF; step(4);

        for (int i = 0; i < 2000; i++) begin
            if (($urandom % 4) == 0) btn_dir_n = 4'($urandom);
            if (($urandom % 4) == 0) btn_act_n = 4'($urandom);
            if (($urandom % 6) == 0) begin
                wr_en = 1'b1; wr_data = 8'($urandom);
            end else begin
                wr_en = 1'b0;
            end
            step(1);
        end
        wr_en = 1'b0;
        step(3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule